// File: doc/BRIEF.md
# Fractional Baud Clock Divider

This block turns a fast reference clock into a stream of single-cycle baud enable strobes whose average spacing is a programmable integer plus a fraction in 1/32 steps of a reference cycle. A serial transmitter or receiver uses the strobe as its bit-time enable. Every individual gap between strobes is a whole number of reference cycles. The block reaches the fractional part by making some periods one cycle longer than others. A 5-bit phase accumulator decides which periods get the extra cycle, so those longer periods are spread evenly.

The divider setting arrives as a 32-bit register-style word that is captured on a write strobe. Only the field in bits 16:3 matters. The integer part sits in bits 16:8 and the fraction in bits 7:3, so the word can also be read as a fixed-point number with 8 fractional bits whose low three are always zero. A new setting can be written while strobes are running. It takes effect at a period boundary and does not reset the accumulator, so the strobe phase carries on without a jump. A countdown output shows how many cycles remain until the next strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, `tick` is low and `remain` is zero. Reset clears the held divider setting to integer 0 and fraction 0.
- R2: After reset is released, the first `tick` occurs in the cycle that follows the first rising clock edge seen with reset high.
- R3: The integer part I is taken from `div_word[16:8]` and the fraction F from `div_word[7:3]`. Bits 31:17 and 2:0 have no effect on any output.
- R4: Each `tick` starts a new period. At that moment the 5-bit accumulator adds F. The period then lasts max(I,1) cycles, plus one more cycle if that addition carried out of 5 bits. The next `tick` marks the end of the period.
- R5: An integer part of zero acts as one. With I = 0 and F = 0, `tick` is high in every cycle.
- R6: Over any 32 consecutive periods with a fixed setting, the cycle count totals exactly 32·max(I,1) + F.
- R7: `div_word` is captured only in a cycle with `div_we` high. Each period uses the setting held when its starting `tick` is sampled, so a write made in a tick cycle first applies to the period after the one that starts there. The accumulator is never cleared by a write.
- R8: In the cycle after a `tick` that starts a period of length L, `remain` equals L−1. It then falls by one each cycle and reaches 0 in the cycle of the next `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Write strobe for the divider word |
| div_word | input | 32 | Divider word; field in bits 16:3 |
| tick | output | 1 | Single-cycle baud enable strobe |
| remain | output | 9 | Cycles left until the next strobe |

## Verification
The bench sweeps every fraction value against several small integer parts, including zero, and also runs the largest integer with the largest fraction. It checks each period's length and each 32-period total. A design that lost the accumulator carry, or cleared the accumulator on a write, would be off by whole cycles in those totals. A design that stalled at integer zero would stop producing strobes. Every write sets the reserved bits to ones and follows with junk on the bus while the strobe is low, so decoding the wrong field would change the period lengths. The single period right after a write is checked against the old setting, which exposes a design that applies a new word too early. The countdown value in the cycle after each tick exposes an off-by-one in the load value.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
   localparam int DEF_WORD_W   = 32;
   localparam int DEF_INT_W    = 9;
   localparam int DEF_FRAC_W   = 5;
   localparam int DEF_FRAC_LSB = 3;

   typedef enum logic {
      VAR_INTEGER_ONLY = 1'b0,
      VAR_DITHERED     = 1'b1
   } fbd_variant_e;

   function automatic fbd_variant_e pick_variant(input int frac_w);
      return (frac_w > 0) ? VAR_DITHERED : VAR_INTEGER_ONLY;
   endfunction
endpackage

// File: rtl/fbd_word_reg.sv
module fbd_word_reg #(
   parameter int WORD_W   = fbd_pkg::DEF_WORD_W,
   parameter int INT_W    = fbd_pkg::DEF_INT_W,
   parameter int FRAC_W   = fbd_pkg::DEF_FRAC_W,
   parameter int FRAC_LSB = fbd_pkg::DEF_FRAC_LSB,
   localparam int FW1     = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] word,
   output logic [INT_W-1:0]  int_q,
   output logic [FW1-1:0]    frac_q
);
   localparam int INT_LSB   = FRAC_LSB + FRAC_W;
   localparam int FIELD_MSB = INT_LSB + INT_W - 1;

   if (FIELD_MSB >= WORD_W) begin : g_bad_width
      $error("divider field does not fit in the word");
   end

   logic [INT_W-1:0] int_d;
   logic [FW1-1:0]   frac_d;

   assign int_d = word[FIELD_MSB:INT_LSB];

   if (FRAC_W > 0) begin : g_frac
      assign frac_d = word[INT_LSB-1:FRAC_LSB];
   end else begin : g_nofrac
      assign frac_d = '0;
   end

   if (FIELD_MSB < WORD_W - 1) begin : g_hi_rsvd
      logic unused_hi;
      assign unused_hi = ^word[WORD_W-1:FIELD_MSB+1];
   end
   if (FRAC_LSB > 0) begin : g_lo_rsvd
      logic unused_lo;
      assign unused_lo = ^word[FRAC_LSB-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= '0;
         frac_q <= '0;
      end else if (we) begin
         int_q  <= int_d;
         frac_q <= frac_d;
      end
   end

   p_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(int_q) && $stable(frac_q)));

   p_capture_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (int_q == $past(word[FIELD_MSB:INT_LSB])));
endmodule

// File: rtl/fbd_accum.sv
module fbd_accum #(
   parameter int FRAC_W = fbd_pkg::DEF_FRAC_W,
   localparam int FW1   = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic [FW1-1:0] frac,
   output logic           carry
);
   localparam fbd_pkg::fbd_variant_e VARIANT = fbd_pkg::pick_variant(FRAC_W);

   if (VARIANT == fbd_pkg::VAR_DITHERED) begin : g_dither
      logic [FW1-1:0] acc_q;
      logic [FW1:0]   sum;

      assign sum   = {1'b0, acc_q} + {1'b0, frac};
      assign carry = sum[FW1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   acc_q <= '0;
         else if (adv) acc_q <= sum[FW1-1:0];
      end

      p_acc_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         !adv |=> $stable(acc_q));

      p_acc_step_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         adv |=> (acc_q == FW1'($past(acc_q) + $past(frac))));
   end else begin : g_plain
      logic unused_in;
      assign unused_in = ^{adv, frac, clk, rst_n};
      assign carry     = 1'b0;
   end
endmodule

// File: rtl/fbd_period_cnt.sv
module fbd_period_cnt #(
   parameter int INT_W = fbd_pkg::DEF_INT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] int_part,
   input  logic             stretch,
   output logic             tick,
   output logic [INT_W-1:0] remain
);
   if (INT_W < 1) begin : g_bad_int
      $error("integer width must be at least one");
   end

   logic             live_q;
   logic [INT_W-1:0] cnt_q;
   logic [INT_W-1:0] base_m1;
   logic [INT_W-1:0] load_val;

   // integer part 0 behaves as 1, so the base period minus one is 0
   assign base_m1  = (int_part == '0) ? '0 : int_part - 1'b1;
   assign load_val = base_m1 + INT_W'(stretch);
   assign tick     = live_q && (cnt_q == '0);
   assign remain   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         live_q <= 1'b1;
         if (tick)        cnt_q <= load_val;
         else if (live_q) cnt_q <= cnt_q - 1'b1;
      end
   end

   p_countdown_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !tick) |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_no_tick_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> !tick);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int WORD_W   = fbd_pkg::DEF_WORD_W,
   parameter int INT_W    = fbd_pkg::DEF_INT_W,
   parameter int FRAC_W   = fbd_pkg::DEF_FRAC_W,
   parameter int FRAC_LSB = fbd_pkg::DEF_FRAC_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              div_we,
   input  logic [WORD_W-1:0] div_word,
   output logic              tick,
   output logic [INT_W-1:0]  remain
);
   localparam int FW1 = (FRAC_W > 0) ? FRAC_W : 1;

   logic [INT_W-1:0] int_q;
   logic [FW1-1:0]   frac_q;
   logic             carry;

   fbd_word_reg #(
      .WORD_W(WORD_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .FRAC_LSB(FRAC_LSB)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .we(div_we), .word(div_word),
      .int_q(int_q), .frac_q(frac_q)
   );

   fbd_accum #(.FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .adv(tick), .frac(frac_q), .carry(carry)
   );

   fbd_period_cnt #(.INT_W(INT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .int_part(int_q), .stretch(carry),
      .tick(tick), .remain(remain)
   );

   p_base_one_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && int_q == '0 && !carry) |=> tick);

   p_reset_remain_r1 : assert property (@(posedge clk)
      !rst_n |-> (remain == '0 && !tick));
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        div_we = 1'b0;
   logic [31:0] div_word = '0;
   wire         tick;
   wire  [8:0]  remain;

   int n_chk = 0;
   int n_bad = 0;
   int acc_m = 0;
   int cur_i = 0;
   int cur_f = 0;
   bit done  = 0;

   frac_baud_gen uut (
      .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_word(div_word),
      .tick(tick), .remain(remain)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model_len(input int i, input int f);
      int s = acc_m + f;
      acc_m = s & 31;
      return ((i == 0) ? 1 : i) + (s >> 5);
   endfunction

   // called at a negedge where tick is high; returns at the next tick negedge
   task automatic period(input string tag, output int len);
      int r1;
      int exp;
      exp = model_len(cur_i, cur_f);
      len = 0;
      r1  = -1;
      do begin
         @(negedge clk);
         len++;
         if (len == 1) begin
            div_we   = 1'b0;
            div_word = 32'h5A5A_5A5A ^ (len * 32'h0001_0F0F);
            r1       = int'(remain);
         end
      end while (!tick && len < 5000);
      chk(len == exp, tag, len, exp);
      if (exp >= 2) chk(r1 == exp - 1, "R8 countdown after tick", r1, exp - 1);
   endtask

   task automatic apply(input int i, input int f, input int n);
      int len;
      int sum;
      int base;
      string tag;
      div_word = (32'(i) << 8) | (32'(f) << 3) | 32'hFFFE_0007;
      div_we   = 1'b1;
      period("R7 old word still used", len);
      cur_i = i;
      cur_f = f;
      tag   = (i == 0) ? "R5 R4 R3 period length" : "R4 R3 period length";
      sum   = 0;
      for (int k = 0; k < n; k++) begin
         period(tag, len);
         sum += len;
      end
      base = (i == 0) ? 1 : i;
      if (n == 32) chk(sum == 32*base + f, "R6 32-period total", sum, 32*base + f);
   endtask

   initial begin
      int len;
      repeat (3) @(negedge clk);
      chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
      chk(remain == 9'd0, "R1 remain in reset", int'(remain), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tick == 1'b1, "R2 first tick", int'(tick), 1);
      for (int k = 0; k < 4; k++) period("R5 R1 zero word every cycle", len);

      for (int ii = 0; ii < 5; ii++) begin
         for (int f = 0; f < 32; f++) begin
            apply((ii == 4) ? 6 : ii, f, 32);
         end
      end
      apply(511, 31, 32);
      apply(300, 1, 32);
      apply(2, 0, 32);
      apply(0, 0, 3);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule